// File: doc/BRIEF.md
# Table-Driven Mealy Controller

This block is a four-state synchronous controller. It has one serial input bit and a two-bit output. All of its behaviour sits in small lookup memories: next-state bits and output bits are read from constant 8-word tables. The tables are addressed by the current state joined to the input bit. A clocked register holds the state and loads the next state from the tables on each rising edge. The outputs come straight from the tables, so they follow the input within a cycle. This makes the machine a Mealy type.

The build-time parameter `MERGED` chooses how the tables are laid out. With `MERGED = 0`, four separate 8x1 memories are used: one per next-state bit and one per output bit. With `MERGED = 1`, a single 8x4 memory returns all four bits from one read. The two variants behave identically at the ports.

The four states are ST_A (00), ST_B (01), ST_C (10) and ST_D (11). The transitions are listed below as state, input, next state / output:

- ST_A, 0 → ST_A / 10
- ST_A, 1 → ST_D / 10
- ST_B, 0 → ST_B / 10
- ST_B, 1 → ST_B / 01
- ST_C, 0 → ST_D / 11
- ST_C, 1 → ST_C / 00
- ST_D, 0 → ST_C / 11
- ST_D, 1 → ST_B / 01

Top module: `rom_mealy_fsm`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `state` reads 00 (ST_A) after that edge.
- R2: When `rst` is low at a rising edge, `state` takes the next-state entry of the transition list for the current state and `din`.
- R3: `dout` always equals the output entry of the transition list for the current `state` and `din`. Bit 1 of `dout` is the first digit of the listed output.
- R4: A change of `din` between clock edges changes `dout` in that same cycle, without any clock edge, and leaves `state` unchanged.
- R5: The merged build (`MERGED = 1`) gives the same `dout` and `state` as the split build for every input sequence.
- R6: The tables are addressed as {state[1], state[0], din}, with state[1] as the most significant bit. Address 3 (ST_B with `din` = 1) therefore yields output 01 and next state ST_B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit |
| dout | output | 2 | Mealy output read from the tables |
| state | output | 2 | Current state register |

## Verification
The assertions assume that `din` is steady around each rising edge and never unknown. They also assume that `rst` is high at the first edge, so that the state starts from a known value. The stimulus changes `din` only at falling edges, or at small offsets inside the low half of the clock. Reset is held from time zero.

The bench visits all eight table addresses by steering the machine from ST_A along known paths. It then runs a long random sequence against a model of the transition list, with both builds side by side.

// File: rtl/rom_fsm_pkg.sv
package rom_fsm_pkg;

    localparam int unsigned STATE_W = 2;
    localparam int unsigned IN_W    = 1;
    localparam int unsigned OUT_W   = 2;
    localparam int unsigned ADDR_W  = STATE_W + IN_W;
    localparam int unsigned DEPTH   = 1 << ADDR_W;
    localparam int unsigned WORD_W  = STATE_W + OUT_W;

    typedef enum logic [STATE_W-1:0] {
        ST_A = 2'b00,
        ST_B = 2'b01,
        ST_C = 2'b10,
        ST_D = 2'b11
    } fsm_state_e;

    // Bit k of each image is the table entry at address k = {state, din}.
    localparam logic [DEPTH-1:0] IMG_NS_HI  = 8'h72;
    localparam logic [DEPTH-1:0] IMG_NS_LO  = 8'h9E;
    localparam logic [DEPTH-1:0] IMG_OUT_HI = 8'h57;
    localparam logic [DEPTH-1:0] IMG_OUT_LO = 8'hD8;

    // Word layout: {next_state[1], next_state[0], out[1], out[0]}
    localparam logic [WORD_W*DEPTH-1:0] BIT_IMAGES =
        {IMG_NS_HI, IMG_NS_LO, IMG_OUT_HI, IMG_OUT_LO};

    function automatic logic [WORD_W*DEPTH-1:0] pack_words(
        input logic [WORD_W*DEPTH-1:0] planes);
        logic [WORD_W*DEPTH-1:0] img;
        img = '0;
        for (int a = 0; a < int'(DEPTH); a++) begin
            for (int b = 0; b < int'(WORD_W); b++) begin
                img[a*WORD_W + b] = planes[b*DEPTH + a];
            end
        end
        return img;
    endfunction

endpackage

// File: rtl/rom_bit.sv
module rom_bit #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DEPTH  = 1 << ADDR_W,
    parameter logic [DEPTH-1:0] CONTENT = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              q
);
    assign q = CONTENT[addr];
endmodule

// File: rtl/rom_word.sv
module rom_word #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned DEPTH  = 1 << ADDR_W,
    parameter logic [WIDTH*DEPTH-1:0] IMAGE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WIDTH-1:0]  q
);
    localparam int unsigned IDX_W = ADDR_W + 3;
    logic [IDX_W-1:0] base;
    assign base = IDX_W'(addr) * IDX_W'(WIDTH);
    assign q    = IMAGE[base +: WIDTH];
endmodule

// File: rtl/rom_fsm_lookup.sv
module rom_fsm_lookup
    import rom_fsm_pkg::*;
#(
    parameter bit MERGED = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    generate
        if (MERGED) begin : g_merged
            rom_word #(
                .ADDR_W (ADDR_W),
                .WIDTH  (WORD_W),
                .DEPTH  (DEPTH),
                .IMAGE  (pack_words(BIT_IMAGES))
            ) u_rom (
                .addr (addr),
                .q    (word)
            );
        end else begin : g_split
            for (genvar b = 0; b < int'(WORD_W); b++) begin : g_plane
                rom_bit #(
                    .ADDR_W  (ADDR_W),
                    .DEPTH   (DEPTH),
                    .CONTENT (BIT_IMAGES[b*DEPTH +: DEPTH])
                ) u_rom (
                    .addr (addr),
                    .q    (word[b])
                );
            end
        end
    endgenerate
endmodule

// File: rtl/rom_fsm_state_reg.sv
module rom_fsm_state_reg
    import rom_fsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fsm_state_e next_state,
    output fsm_state_e cur_state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= ST_A;
        end else begin
            cur_state <= next_state;
        end
    end
endmodule

// File: rtl/rom_mealy_fsm.sv
module rom_mealy_fsm
    import rom_fsm_pkg::*;
#(
    parameter bit MERGED = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [OUT_W-1:0] dout,
    output logic [STATE_W-1:0] state
);
    fsm_state_e             cur_state;
    fsm_state_e             next_state;
    logic [ADDR_W-1:0]      rom_addr;
    logic [WORD_W-1:0]      rom_word_q;

    assign rom_addr = {cur_state, din};

    rom_fsm_lookup #(.MERGED(MERGED)) u_lookup (
        .addr (rom_addr),
        .word (rom_word_q)
    );

    // Next-state decode from the table word
    always_comb begin
        unique case (rom_word_q[WORD_W-1 -: STATE_W])
            2'b00:   next_state = ST_A;
            2'b01:   next_state = ST_B;
            2'b10:   next_state = ST_C;
            default: next_state = ST_D;
        endcase
    end

    rom_fsm_state_reg u_state (
        .clk        (clk),
        .rst        (rst),
        .next_state (next_state),
        .cur_state  (cur_state)
    );

    // Output process
    always_comb begin
        dout  = rom_word_q[OUT_W-1:0];
        state = cur_state;
    end
endmodule

// File: rtl/rom_fsm_checker.sv
module rom_fsm_checker
    import rom_fsm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               din,
    input logic [OUT_W-1:0]   dout,
    input logic [STATE_W-1:0] state
);
    function automatic logic [1:0] exp_ns(input logic [2:0] a);
        return {IMG_NS_HI[a], IMG_NS_LO[a]};
    endfunction

    function automatic logic [1:0] exp_out(input logic [2:0] a);
        return {IMG_OUT_HI[a], IMG_OUT_LO[a]};
    endfunction

    AST_RESET_TO_A: assert property (@(posedge clk) rst |=> state == 2'b00); // R1
    AST_NEXT_STATE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state == exp_ns($past({state, din}))); // R2
    AST_OUT_TABLE: assert property (@(posedge clk) disable iff (rst)
        dout == exp_out({state, din})); // R3
    AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01 && din) |-> dout == 2'b01); // R6
    AST_STATE_KNOWN: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({state, dout})); // R2
endmodule

bind rom_mealy_fsm rom_fsm_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .dout  (dout),
    .state (state)
);

// File: tb/tb_rom_mealy_fsm.sv
module tb_rom_mealy_fsm;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [1:0] dout_s, dout_m, st_s, st_m;
    logic [1:0] model_st;
    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    rom_mealy_fsm #(.MERGED(1'b0)) dut (
        .clk(clk), .rst(rst), .din(din), .dout(dout_s), .state(st_s));
    rom_mealy_fsm #(.MERGED(1'b1)) dut_merged (
        .clk(clk), .rst(rst), .din(din), .dout(dout_m), .state(st_m));

    function automatic logic [3:0] ref_row(input logic [1:0] s, input logic i);
        case ({s, i})
            3'b000: return 4'b00_10;
            3'b001: return 4'b11_10;
            3'b010: return 4'b01_10;
            3'b011: return 4'b01_01;
            3'b100: return 4'b11_11;
            3'b101: return 4'b10_00;
            3'b110: return 4'b10_11;
            default: return 4'b01_01;
        endcase
    endfunction

    task automatic check2(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; din = 1'b0;
        @(posedge clk); #1;
        model_st = 2'b00;
        check2("R1", st_s, 2'b00);
        check2("R1", st_m, 2'b00);
        @(negedge clk); rst = 1'b0;
    endtask

    // One cycle: drive din, check outputs mid-cycle, clock, check state
    task automatic step(input logic v, input string rq);
        logic [3:0] row;
        @(negedge clk); din = v; #1;
        row = ref_row(model_st, v);
        check2(rq, dout_s, row[1:0]);
        check2("R5", dout_m, dout_s);
        @(posedge clk); #1;
        model_st = row[3:2];
        check2(rq, st_s, model_st);
        check2("R5", st_m, st_s);
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        model_st = 2'b00;
        repeat (2) @(posedge clk);
        #1;
        check2("R1", st_s, 2'b00);
        @(negedge clk); rst = 1'b0;

        // Exhaustive sweep of all 8 addresses, R2/R3/R6
        for (int a = 0; a < 8; a++) begin
            do_reset();
            case (a >> 1)
                1: begin step(1'b1, "R2"); step(1'b1, "R2"); end
                2: begin step(1'b1, "R2"); step(1'b0, "R2"); end
                3: step(1'b1, "R2");
                default: ;
            endcase
            step(a[0], (a == 3) ? "R6" : "R3");
        end

        // R4: din toggles inside one cycle, no edge in between
        for (int s = 0; s < 4; s++) begin
            do_reset();
            case (s)
                1: begin step(1'b1, "R2"); step(1'b1, "R2"); end
                2: begin step(1'b1, "R2"); step(1'b0, "R2"); end
                3: step(1'b1, "R2");
                default: ;
            endcase
            @(negedge clk); din = 1'b0; #1;
            check2("R4", dout_s, ref_row(model_st, 1'b0) ==? 4'bxxxx ? ref_row(model_st, 1'b0)[1:0] : 2'bxx);
            din = 1'b1; #1;
            check2("R4", dout_s, ref_row(model_st, 1'b1)[1:0]);
            check2("R4", st_s, model_st);
            din = 1'b0; #1;
            check2("R4", dout_s, ref_row(model_st, 1'b0)[1:0]);
            check2("R5", dout_m, dout_s);
        end

        // Random run with mid-run resets, R2/R3/R5
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            if (n % 700 == 699) do_reset();
            step(1'($urandom), "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule